// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the entry half of an interrupt for a small 16-bit processor. When it is idle and sees a request, it accepts the request and takes a snapshot of everything it needs in that same cycle. The snapshot holds the handler vector, the interrupt argument, the A, B and C registers, the 32-bit program counter, the frame pointer and the stack pointer. It then writes seven 16-bit words onto a stack that grows toward lower addresses, one word per accepted write, through a plain write port with a ready handshake.

The first word written is the argument, such as a key code, a remote-control key number or a breakpoint index. After it come C, B, A, the upper half of the PC, the lower half of the PC and FP. Because of this order, the handler finds the same frame layout that an ordinary call produces. After the last write is accepted, the block pulses load strobes for PC, FP and SP in a single cycle, together with a done pulse. PC receives the vector. FP and SP both receive the stack pointer value left after the final push.

Arbitration between interrupt sources is handled elsewhere, and so is the return from the handler. Requests that arrive while a sequence is running are not accepted.

Top module: `irq_entry_seq`

## Requirements
- R1: During and after reset, the block is idle. mem_wr_en, irq_ack, done and all three load strobes are 0.
- R2: irq_ack is 1 in any cycle where the block is idle and irq_req is 1. That cycle's vector, argument and register inputs are captured at the next rising edge, and the first write is presented in the following cycle.
- R3: Word k (k = 0..6) carries, in this order: the argument, C, B, A, PC[31:16], PC[15:0], FP.
- R4: Word k is written at the captured SP minus 2*k, computed modulo 2^16.
- R5: While mem_wr_en is 1 and mem_ready is 0, the address and data stay unchanged. A write counts as accepted on a rising edge where both are 1, and the next word is presented in the following cycle.
- R6: In the cycle after the seventh accepted write, pc_load, fp_load, sp_load and done are all 1 for exactly one cycle, mem_wr_en is 0, and pc_value equals the captured vector.
- R7: In the load cycle, sp_value and fp_value both equal the captured SP minus 14, modulo 2^16.
- R8: While a sequence is running, irq_req has no effect: irq_ack stays 0 and the words being written do not change. A request made once the block is idle again is accepted.
- R9: Changes on the vector, argument or register inputs after the accept cycle do not alter any word written or any value loaded.
- R10: A captured SP close to zero wraps correctly: addresses below 0 continue from 0xFFFE downward, and the final SP and FP wrap in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Interrupt request from the arbiter |
| irq_vector | input | 32 | Handler entry address |
| irq_arg | input | 16 | Argument word pushed first |
| reg_a | input | 16 | Current A register |
| reg_b | input | 16 | Current B register |
| reg_c | input | 16 | Current C register |
| cur_pc | input | 32 | Current program counter |
| cur_fp | input | 16 | Current frame pointer |
| cur_sp | input | 16 | Current stack pointer |
| mem_ready | input | 1 | Memory accepts the presented write |
| irq_ack | output | 1 | Request accepted in this cycle |
| busy | output | 1 | A sequence is running |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | 16 | Byte address of the word being written |
| mem_wdata | output | 16 | Word being written |
| pc_load | output | 1 | Load strobe for the PC |
| pc_value | output | 32 | New PC value |
| fp_load | output | 1 | Load strobe for the FP |
| fp_value | output | 16 | New FP value |
| sp_load | output | 1 | Load strobe for the SP |
| sp_value | output | 16 | New SP value |
| done | output | 1 | Sequence complete, one-cycle pulse |

## Verification
irq_ack is combinational, so the bench checks it in the same cycle it raises the request. The first word is due one edge after acceptance. Each later word is due one edge after the edge where mem_ready was seen high, and a stalled word must still be present, unchanged, one edge after a cycle with mem_ready low. The load and done strobes are due one edge after the seventh accepted write, and the block is idle one edge after that. The bench drives its inputs on the falling edge and samples the outputs shortly afterwards. Because it tracks which edges accepted a write, each expected word and strobe is compared in exactly the cycle it is due.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  parameter int DATA_W     = 16;
  parameter int PC_W       = 32;
  parameter int WORD_BYTES = 2;
  parameter int NUM_SLOTS  = 7;
  parameter int SLOT_W     = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PUSH   = 2'd1,
    SEQ_FINISH = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [PC_W-1:0]   vec;
    logic [DATA_W-1:0] arg;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] c;
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] fp;
    logic [DATA_W-1:0] sp;
  } entry_ctx_t;

  // Byte address of push slot idx, counted down from the captured SP.
  function automatic logic [DATA_W-1:0] slot_addr(input logic [DATA_W-1:0] sp0,
                                                  input logic [SLOT_W-1:0] idx);
    logic [DATA_W-1:0] off;
    off = DATA_W'(idx) * DATA_W'(WORD_BYTES);
    return sp0 - off;
  endfunction

  // Stack pointer once every slot has been pushed.
  function automatic logic [DATA_W-1:0] final_sp(input logic [DATA_W-1:0] sp0);
    return sp0 - DATA_W'(NUM_SLOTS * WORD_BYTES);
  endfunction

endpackage

// File: rtl/irq_ctx_capture.sv
module irq_ctx_capture
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  entry_ctx_t live_ctx,
  output entry_ctx_t held_ctx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_ctx <= '0;
    end else if (capture) begin
      held_ctx <= live_ctx;
    end
  end

endmodule

// File: rtl/irq_slot_mux.sv
module irq_slot_mux
  import irq_entry_pkg::*;
(
  input  entry_ctx_t        ctx,
  input  logic [SLOT_W-1:0] idx,
  output logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] addr
);

  localparam int HALF = PC_W / 2;

  logic [DATA_W-1:0] slot_words [NUM_SLOTS];

  // Push order: argument, C, B, A, PC high, PC low, FP.
  assign slot_words[0] = ctx.arg;
  assign slot_words[1] = ctx.c;
  assign slot_words[2] = ctx.b;
  assign slot_words[3] = ctx.a;
  assign slot_words[4] = DATA_W'(ctx.pc[PC_W-1:HALF]);
  assign slot_words[5] = DATA_W'(ctx.pc[HALF-1:0]);
  assign slot_words[6] = ctx.fp;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (idx == SLOT_W'(i)) word = slot_words[i];
    end
  end

  assign addr = slot_addr(ctx.sp, idx);

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              mem_ready,
  output logic              accept,
  output logic              busy,
  output logic              wr_en,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              finish
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  seq_state_t state_q, state_d;
  logic [SLOT_W-1:0] idx_d;
  logic write_accept;
  logic last_slot;

  assign accept       = (state_q == SEQ_IDLE) && irq_req;
  assign busy         = (state_q != SEQ_IDLE);
  assign wr_en        = (state_q == SEQ_PUSH);
  assign finish       = (state_q == SEQ_FINISH);
  assign write_accept = wr_en && mem_ready;
  assign last_slot    = (slot_idx == LAST_SLOT);

  always_comb begin
    state_d = state_q;
    idx_d   = slot_idx;
    unique case (state_q)
      SEQ_IDLE: begin
        if (irq_req) begin
          state_d = SEQ_PUSH;
          idx_d   = '0;
        end
      end
      SEQ_PUSH: begin
        if (write_accept) begin
          if (last_slot) state_d = SEQ_FINISH;
          else           idx_d   = slot_idx + 1'b1;
        end
      end
      SEQ_FINISH: begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end
      default: begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      slot_idx <= '0;
    end else begin
      state_q  <= state_d;
      slot_idx <= idx_d;
    end
  end

  AST_MASK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept); // R8
  AST_STALL_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mem_ready) |=> (wr_en && $stable(slot_idx))); // R5
  AST_LAST_THEN_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (write_accept && last_slot) |=> (finish && !wr_en)); // R6
  AST_FINISH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish); // R6
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wr_en && slot_idx == '0)); // R2

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [PC_W-1:0]   irq_vector,
  input  logic [DATA_W-1:0] irq_arg,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [DATA_W-1:0] reg_c,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [DATA_W-1:0] cur_fp,
  input  logic [DATA_W-1:0] cur_sp,
  input  logic              mem_ready,
  output logic              irq_ack,
  output logic              busy,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic              fp_load,
  output logic [DATA_W-1:0] fp_value,
  output logic              sp_load,
  output logic [DATA_W-1:0] sp_value,
  output logic              done
);

  entry_ctx_t        live_ctx;
  entry_ctx_t        held_ctx;
  logic              seq_accept;
  logic              seq_finish;
  logic [SLOT_W-1:0] seq_slot;
  logic [DATA_W-1:0] slot_word;
  logic [DATA_W-1:0] slot_address;

  assign live_ctx = '{vec: irq_vector, arg: irq_arg, a: reg_a, b: reg_b,
                      c: reg_c, pc: cur_pc, fp: cur_fp, sp: cur_sp};

  irq_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .mem_ready (mem_ready),
    .accept    (seq_accept),
    .busy      (busy),
    .wr_en     (mem_wr_en),
    .slot_idx  (seq_slot),
    .finish    (seq_finish)
  );

  irq_ctx_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (seq_accept),
    .live_ctx (live_ctx),
    .held_ctx (held_ctx)
  );

  irq_slot_mux u_mux (
    .ctx  (held_ctx),
    .idx  (seq_slot),
    .word (slot_word),
    .addr (slot_address)
  );

  assign irq_ack   = seq_accept;
  assign mem_addr  = slot_address;
  assign mem_wdata = slot_word;
  assign pc_load   = seq_finish;
  assign fp_load   = seq_finish;
  assign sp_load   = seq_finish;
  assign done      = seq_finish;
  assign pc_value  = held_ctx.vec;
  assign sp_value  = final_sp(held_ctx.sp);
  assign fp_value  = sp_value;

  AST_STALL_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata))); // R5
  AST_ADDR_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_ready) |=> (!mem_wr_en ||
      mem_addr == $past(mem_addr) - DATA_W'(WORD_BYTES))); // R4
  AST_LOADS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (fp_load && sp_load && done && !mem_wr_en)); // R6
  AST_FP_MATCHES_SP: assert property (@(posedge clk) disable iff (!rst_n)
    fp_load |-> (fp_value == sp_value)); // R7
  AST_HELD_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !irq_ack) |=> $stable(pc_value)); // R9

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [31:0] irq_vector = '0;
  logic [15:0] irq_arg = '0, reg_a = '0, reg_b = '0, reg_c = '0;
  logic [31:0] cur_pc = '0;
  logic [15:0] cur_fp = '0, cur_sp = '0;
  logic        mem_ready = 1'b0;
  logic        irq_ack, busy, mem_wr_en, pc_load, fp_load, sp_load, done;
  logic [15:0] mem_addr, mem_wdata, fp_value, sp_value;
  logic [31:0] pc_value;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int seed_dummy;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vector(irq_vector),
    .irq_arg(irq_arg), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .cur_pc(cur_pc), .cur_fp(cur_fp), .cur_sp(cur_sp), .mem_ready(mem_ready),
    .irq_ack(irq_ack), .busy(busy), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value),
    .fp_load(fp_load), .fp_value(fp_value), .sp_load(sp_load),
    .sp_value(sp_value), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word k from the push order of R3.
  function automatic logic [15:0] exp_word(input int k, input logic [15:0] arg,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
      input logic [31:0] pc, input logic [15:0] fp);
    case (k)
      0: return arg;
      1: return c;
      2: return b;
      3: return a;
      4: return pc[31:16];
      5: return pc[15:0];
      default: return fp;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] sp, input int k);
    return 16'(int'(sp) - 2 * k);
  endfunction

  task automatic run_entry(input logic [15:0] sp, input logic hold_req, input logic stall_en);
    logic [31:0] vec, pc;
    logic [15:0] arg, a, b, c, fp;
    int k;
    int stalls;
    logic rdy;
    vec = $urandom; pc = $urandom; arg = 16'($urandom);
    a = 16'($urandom); b = 16'($urandom); c = 16'($urandom); fp = 16'($urandom);
    @(negedge clk);
    irq_vector = vec; cur_pc = pc; irq_arg = arg; reg_a = a; reg_b = b;
    reg_c = c; cur_fp = fp; cur_sp = sp; irq_req = 1'b1; mem_ready = 1'b0;
    #1;
    check("R2 ack while idle", {31'd0, irq_ack}, 32'd1);
    check("R1 no write before accept", {31'd0, mem_wr_en}, 32'd0);
    @(negedge clk);
    irq_req = hold_req;
    // R9: scramble live inputs once captured
    irq_vector = ~vec; cur_pc = ~pc; irq_arg = ~arg; reg_a = ~a; reg_b = ~b;
    reg_c = ~c; cur_fp = ~fp; cur_sp = ~sp;
    k = 0;
    stalls = 0;
    while (k < 7) begin
      rdy = (!stall_en || stalls >= 3) ? 1'b1 : 1'($urandom % 2);
      mem_ready = rdy;
      #1;
      check("R5 write strobe", {31'd0, mem_wr_en}, 32'd1);
      check("R3 R9 word data", {16'd0, mem_wdata}, {16'd0, exp_word(k, arg, a, b, c, pc, fp)});
      check("R4 R10 word address", {16'd0, mem_addr}, {16'd0, exp_addr(sp, k)});
      check("R8 no ack while busy", {31'd0, irq_ack}, 32'd0);
      if (rdy) begin
        k++;
        stalls = 0;
      end else begin
        stalls++;
      end
      @(negedge clk);
    end
    irq_req = 1'b0;
    mem_ready = 1'b0;
    #1;
    check("R6 loads and done", {28'd0, pc_load, fp_load, sp_load, done}, 32'hF);
    check("R6 no write in load cycle", {31'd0, mem_wr_en}, 32'd0);
    check("R6 R9 pc value", pc_value, vec);
    check("R7 R10 sp value", {16'd0, sp_value}, {16'd0, exp_addr(sp, 7)});
    check("R7 fp value", {16'd0, fp_value}, {16'd0, exp_addr(sp, 7)});
    @(negedge clk);
    #1;
    check("R6 single done pulse", {29'd0, done, pc_load, busy}, 32'd0);
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset outputs", {26'd0, mem_wr_en, irq_ack, done, pc_load, fp_load, sp_load}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 idle after reset", {30'd0, busy, mem_wr_en}, 32'd0);

    run_entry(16'h8000, 1'b0, 1'b0);   // directed, no stalls
    run_entry(16'h0004, 1'b1, 1'b1);   // R10 wrap, request held (R8)
    run_entry(16'h0000, 1'b0, 1'b1);   // R10 wrap from zero
    run_entry(16'hFFFE, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      run_entry(16'($urandom) & 16'hFFFE, 1'($urandom % 2), 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule